// File: doc/BRIEF.md
# Write-Through Snooping Cache Controller

This block sits between one processor and a shared, atomic system bus in a small multiprocessor. It keeps a direct-mapped cache of one word per line and keeps it coherent with the other caches on the bus using only two line states: a line is either usable (valid) or not (invalid). A line that was never loaded and a line that was knocked out by another cache are both simply invalid. No line is ever dirty, because every processor write goes out to the bus at once. A write never brings a line into the cache.

The processor presents a request and holds it until the controller answers with a one-cycle ready pulse. Only one request is handled at a time, in the order given. A read that finds its line valid is answered from the local array without touching the bus. A read miss and every write run a bus transaction in three steps: request and wait for grant, one command cycle carrying the address (and the data for a write), then a data phase that ends with an acknowledge from memory. The controller watches every transaction on the shared bus. A write by another cache to a word it holds drops that line to invalid. Its own transactions, seen while it owns the bus, are ignored.

Top module: `wt_snoop_cache`

## Requirements
- R1: While reset is asserted and just after it, every line is invalid, and cpu_ready, bus_req and bus_cmd_valid are 0. The first read of any address after reset therefore goes to the bus.
- R2: A read whose line is invalid, or whose stored tag differs, raises bus_req. It issues one read command (bus_cmd_we = 0) with the request address. It returns bus_rdata from the acknowledged data phase on cpu_rdata. The line is then valid with that word.
- R3: A read that hits a valid line issues no bus command. It raises cpu_ready in the cycle after the request is accepted, with the stored word on cpu_rdata.
- R4: Every write, hit or miss, issues one bus write command (bus_cmd_we = 1) carrying the address and data. A write miss leaves the line invalid, so a later read of that address goes to the bus. A write hit also updates the local word, so a later read hits and returns the new value.
- R5: A snooped write (snoop_valid = 1, snoop_we = 1) from another cache whose address matches a valid line makes that line invalid. The next processor read of that address goes to the bus.
- R6: bus_cmd_valid is high for exactly one cycle, in the cycle after bus_gnt was seen high, with bus_req high. bus_req stays high from the request through the data phase and is low again when cpu_ready rises.
- R7: A snooped read, and a snooped write whose tag differs from the stored line at the same index, leave the line valid.
- R8: cpu_ready is a single-cycle pulse. After it, the controller is idle: bus_req is low and no further bus command appears until a new request.
- R9: Bus activity seen on the snoop inputs while this controller owns the bus (its own command and data phase) is ignored. Its own write to a valid line leaves the line valid with the new data.
- R10: When a snooped write from another cache and a processor read to the same valid line arrive in the same cycle, the invalidation is applied first. The read misses and fetches from the bus.
- R11: The array is direct-mapped: the index is the low log2(LINES) address bits and the tag is the remaining upper bits. A read miss to a different tag at an occupied index replaces that line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid while cpu_ready is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request, held for the whole transaction |
| bus_gnt | input | 1 | Bus grant from the external arbiter |
| bus_cmd_valid | output | 1 | Command/address cycle |
| bus_cmd_we | output | 1 | Command kind: 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Command address |
| bus_wdata | output | DATA_W | Write data of the command |
| bus_ack | input | 1 | Data phase complete |
| bus_rdata | input | DATA_W | Read data of the data phase |
| snoop_valid | input | 1 | A transaction is visible on the shared bus |
| snoop_we | input | 1 | The snooped transaction is a write |
| snoop_addr | input | ADDR_W | Address of the snooped transaction |

## Verification
The bench builds the controller with its defaults: 8 lines, 16-bit word addresses and 32-bit data. With these values addresses 0x10 and 0x18 share index 0, which makes replacement by a conflicting tag easy to reach. Address 0x2B shares index 3 with 0x23 but has another tag, which lets the bench check that a snoop with a different tag is ignored. The bench's bus model feeds the controller's own commands back onto the snoop inputs, as a real shared bus would. This puts self-snooping, same-cycle snoop-versus-read collisions and hit/miss latency all within reach of plain directed sequences.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    // controller sequencing states
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a processor request
        ST_ARB,    // bus requested, waiting for grant
        ST_CMD,    // command/address cycle on the bus
        ST_DATA,   // data phase, waiting for acknowledge
        ST_DONE    // ready pulse to the processor
    } wtc_state_e;

endpackage

// File: rtl/wtc_line_array.sv
module wtc_line_array #(
    parameter int LINES  = 8,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 13,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    // processor-side lookup port
    input  logic [IDX_W-1:0]              rd_idx,
    output logic                          rd_valid,
    output logic [TAG_W-1:0]              rd_tag,
    output logic [DATA_W-1:0]             rd_data,
    // snoop-side lookup port
    input  logic [IDX_W-1:0]              sn_idx,
    output logic                          sn_valid,
    output logic [TAG_W-1:0]              sn_tag,
    // write port
    input  logic                          fill_en,
    input  logic                          upd_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [TAG_W-1:0]              wr_tag,
    input  logic [DATA_W-1:0]             wr_data,
    // invalidate port
    input  logic                          inv_en,
    input  logic [IDX_W-1:0]              inv_idx,
    // whole-array views
    output logic [LINES-1:0]              valid_vec,
    output logic [LINES-1:0][TAG_W-1:0]   tag_vec
);

    logic [LINES-1:0][DATA_W-1:0] data_vec;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);

        logic              vld_d, vld_q;
        logic [TAG_W-1:0]  tag_d, tag_q;
        logic [DATA_W-1:0] dat_d, dat_q;

        always_comb begin
            vld_d = vld_q;
            tag_d = tag_q;
            dat_d = dat_q;
            if ((fill_en || upd_en) && wr_idx == MY_IDX) begin
                dat_d = wr_data;
                if (fill_en) begin
                    vld_d = 1'b1;
                    tag_d = wr_tag;
                end
            end
            // invalidation has the last word
            if (inv_en && inv_idx == MY_IDX) begin
                vld_d = 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
                tag_q <= '0;
                dat_q <= '0;
            end else begin
                vld_q <= vld_d;
                tag_q <= tag_d;
                dat_q <= dat_d;
            end
        end

        assign valid_vec[i] = vld_q;
        assign tag_vec[i]   = tag_q;
        assign data_vec[i]  = dat_q;
    end

    assign rd_valid = valid_vec[rd_idx];
    assign rd_tag   = tag_vec[rd_idx];
    assign rd_data  = data_vec[rd_idx];
    assign sn_valid = valid_vec[sn_idx];
    assign sn_tag   = tag_vec[sn_idx];

endmodule

// File: rtl/wtc_snoop_filter.sv
module wtc_snoop_filter #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              snoop_valid,
    input  logic              snoop_we,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              own_bus,
    // state of the line at the snooped index
    input  logic              sn_valid,
    input  logic [TAG_W-1:0]  sn_tag,
    output logic [IDX_W-1:0]  sn_idx,
    output logic              inv_en,
    output logic [IDX_W-1:0]  inv_idx
);

    logic [TAG_W-1:0] snoop_tag;
    logic             foreign_wr;

    assign sn_idx     = snoop_addr[IDX_W-1:0];
    assign snoop_tag  = snoop_addr[ADDR_W-1:IDX_W];
    // a write seen while this controller holds the bus is its own
    assign foreign_wr = snoop_valid && snoop_we && !own_bus;
    assign inv_en     = foreign_wr && sn_valid && (sn_tag == snoop_tag);
    assign inv_idx    = sn_idx;

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    // processor side
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    // bus side
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd_valid,
    output logic              bus_cmd_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    // array interface
    output logic [ADDR_W-1:0] look_addr,
    input  logic              look_hit,
    input  logic [DATA_W-1:0] look_data,
    output logic              fill_en,
    output logic              upd_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    // status to snoop path and checker
    output logic              own_bus,
    output logic              pend_we
);

    typedef struct packed {
        wtc_state_e        state;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } ctrl_regs_t;

    ctrl_regs_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        fill_en = 1'b0;
        upd_en  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cpu_req) begin
                    r_d.we    = cpu_we;
                    r_d.addr  = cpu_addr;
                    r_d.wdata = cpu_wdata;
                    if (!cpu_we && look_hit) begin
                        r_d.rdata = look_data;
                        r_d.state = ST_DONE;
                    end else begin
                        r_d.state = ST_ARB;
                    end
                end
            end
            ST_ARB: begin
                if (bus_gnt) begin
                    r_d.state = ST_CMD;
                end
            end
            ST_CMD: begin
                r_d.state = ST_DATA;
            end
            ST_DATA: begin
                if (bus_ack) begin
                    if (!r_q.we) begin
                        r_d.rdata = bus_rdata;
                        fill_en   = 1'b1;
                    end else if (look_hit) begin
                        upd_en    = 1'b1;
                    end
                    r_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, we: 1'b0, addr: '0, wdata: '0, rdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign look_addr     = (r_q.state == ST_IDLE) ? cpu_addr : r_q.addr;
    assign wr_addr       = r_q.addr;
    assign wr_data       = r_q.we ? r_q.wdata : bus_rdata;

    assign bus_req       = (r_q.state == ST_ARB) || (r_q.state == ST_CMD) ||
                           (r_q.state == ST_DATA);
    assign bus_cmd_valid = (r_q.state == ST_CMD);
    assign bus_cmd_we    = r_q.we;
    assign bus_addr      = r_q.addr;
    assign bus_wdata     = r_q.wdata;
    assign own_bus       = (r_q.state == ST_CMD) || (r_q.state == ST_DATA);
    assign pend_we       = r_q.we;

    assign cpu_ready     = (r_q.state == ST_DONE);
    assign cpu_rdata     = r_q.rdata;

endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LINES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd_valid,
    output logic              bus_cmd_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snoop_valid,
    input  logic              snoop_we,
    input  logic [ADDR_W-1:0] snoop_addr
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [ADDR_W-1:0]            look_addr;
    logic                         look_hit;
    logic [DATA_W-1:0]            look_data;
    logic                         fill_en;
    logic                         upd_en;
    logic [ADDR_W-1:0]            wr_addr;
    logic [DATA_W-1:0]            wr_data;
    logic                         own_bus;
    logic                         pend_we;

    logic                         rd_valid;
    logic [TAG_W-1:0]             rd_tag;
    logic [IDX_W-1:0]             sn_idx;
    logic                         sn_valid;
    logic [TAG_W-1:0]             sn_tag;
    logic                         inv_en;
    logic [IDX_W-1:0]             inv_idx;
    logic [LINES-1:0]             line_valid;
    logic [LINES-1:0][TAG_W-1:0]  line_tag;

    logic [IDX_W-1:0]             look_idx;
    logic [TAG_W-1:0]             look_tag;

    assign look_idx = look_addr[IDX_W-1:0];
    assign look_tag = look_addr[ADDR_W-1:IDX_W];
    // a same-cycle invalidation of the looked-up line wins over the hit
    assign look_hit = rd_valid && (rd_tag == look_tag) &&
                      !(inv_en && inv_idx == look_idx);

    wtc_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req       (cpu_req),
        .cpu_we        (cpu_we),
        .cpu_addr      (cpu_addr),
        .cpu_wdata     (cpu_wdata),
        .cpu_rdata     (cpu_rdata),
        .cpu_ready     (cpu_ready),
        .bus_req       (bus_req),
        .bus_gnt       (bus_gnt),
        .bus_cmd_valid (bus_cmd_valid),
        .bus_cmd_we    (bus_cmd_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_ack       (bus_ack),
        .bus_rdata     (bus_rdata),
        .look_addr     (look_addr),
        .look_hit      (look_hit),
        .look_data     (look_data),
        .fill_en       (fill_en),
        .upd_en        (upd_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .own_bus       (own_bus),
        .pend_we       (pend_we)
    );

    wtc_line_array #(
        .LINES  (LINES),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (look_idx),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_data   (look_data),
        .sn_idx    (sn_idx),
        .sn_valid  (sn_valid),
        .sn_tag    (sn_tag),
        .fill_en   (fill_en),
        .upd_en    (upd_en),
        .wr_idx    (wr_addr[IDX_W-1:0]),
        .wr_tag    (wr_addr[ADDR_W-1:IDX_W]),
        .wr_data   (wr_data),
        .inv_en    (inv_en),
        .inv_idx   (inv_idx),
        .valid_vec (line_valid),
        .tag_vec   (line_tag)
    );

    wtc_snoop_filter #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_snoop (
        .snoop_valid (snoop_valid),
        .snoop_we    (snoop_we),
        .snoop_addr  (snoop_addr),
        .own_bus     (own_bus),
        .sn_valid    (sn_valid),
        .sn_tag      (sn_tag),
        .sn_idx      (sn_idx),
        .inv_en      (inv_en),
        .inv_idx     (inv_idx)
    );

endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
    parameter int ADDR_W = 16,
    parameter int LINES  = 8,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cpu_ready,
    input logic                         bus_req,
    input logic                         bus_gnt,
    input logic                         bus_cmd_valid,
    input logic                         bus_ack,
    input logic                         snoop_valid,
    input logic                         snoop_we,
    input logic [ADDR_W-1:0]            snoop_addr,
    input logic                         own_bus,
    input logic                         pend_we,
    input logic [LINES-1:0]             line_valid,
    input logic [LINES-1:0][TAG_W-1:0]  line_tag
);

    logic [IDX_W-1:0] s_idx;
    logic [TAG_W-1:0] s_tag;
    assign s_idx = snoop_addr[IDX_W-1:0];
    assign s_tag = snoop_addr[ADDR_W-1:IDX_W];

    // R6: command cycle only after a grant, while the bus is requested
    a_r6_cmd_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_valid |-> ($past(bus_gnt) && bus_req));

    // R6: the command cycle lasts one cycle
    a_r6_cmd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_valid |=> !bus_cmd_valid);

    // R8: ready is a single-cycle pulse
    a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R8: no bus ownership while answering the processor
    a_r8_ready_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !bus_req);

    // R5: a foreign write to a held line drops it
    a_r5_snoop_inval: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid && snoop_we && !own_bus && line_valid[s_idx] &&
         line_tag[s_idx] == s_tag) |=> !line_valid[$past(s_idx)]);

    // R4: a line only becomes valid at the end of an own read data phase
    a_r4_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (|(line_valid & ~$past(line_valid))) |->
            $past(own_bus && bus_ack && !pend_we));

endmodule

bind wt_snoop_cache wtc_checker #(
    .ADDR_W (ADDR_W),
    .LINES  (LINES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_ready     (cpu_ready),
    .bus_req       (bus_req),
    .bus_gnt       (bus_gnt),
    .bus_cmd_valid (bus_cmd_valid),
    .bus_ack       (bus_ack),
    .snoop_valid   (snoop_valid),
    .snoop_we      (snoop_we),
    .snoop_addr    (snoop_addr),
    .own_bus       (own_bus),
    .pend_we       (pend_we),
    .line_valid    (line_valid),
    .line_tag      (line_tag)
);

// File: tb/wt_snoop_cache_tb.sv
module wt_snoop_cache_tb;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int LINES  = 8;
    localparam int NVEC   = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0;
    logic              cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic [DATA_W-1:0] cpu_rdata;
    logic              cpu_ready;
    logic              bus_req;
    logic              bus_gnt = 1'b0;
    logic              bus_cmd_valid;
    logic              bus_cmd_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic              bus_ack = 1'b0;
    logic [DATA_W-1:0] bus_rdata = '0;
    logic              snoop_valid;
    logic              snoop_we;
    logic [ADDR_W-1:0] snoop_addr;

    // other-cache snoop stimulus; own commands are echoed as on a real bus
    logic              ext_sv = 1'b0;
    logic              ext_swe = 1'b0;
    logic [ADDR_W-1:0] ext_sa = '0;
    assign snoop_valid = ext_sv | bus_cmd_valid;
    assign snoop_we    = bus_cmd_valid ? bus_cmd_we : ext_swe;
    assign snoop_addr  = bus_cmd_valid ? bus_addr : ext_sa;

    always #4 clk = ~clk;

    wt_snoop_cache #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LINES  (LINES)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req       (cpu_req),
        .cpu_we        (cpu_we),
        .cpu_addr      (cpu_addr),
        .cpu_wdata     (cpu_wdata),
        .cpu_rdata     (cpu_rdata),
        .cpu_ready     (cpu_ready),
        .bus_req       (bus_req),
        .bus_gnt       (bus_gnt),
        .bus_cmd_valid (bus_cmd_valid),
        .bus_cmd_we    (bus_cmd_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_ack       (bus_ack),
        .bus_rdata     (bus_rdata),
        .snoop_valid   (snoop_valid),
        .snoop_we      (snoop_we),
        .snoop_addr    (snoop_addr)
    );

    int checks = 0;
    int fails  = 0;
    int ncmd   = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model behind the bus
    logic [DATA_W-1:0] mem [256];
    logic              exp_we;
    logic [ADDR_W-1:0] exp_addr;
    logic [DATA_W-1:0] exp_wdata;
    logic [ADDR_W-1:0] lat_addr;
    logic              lat_we;
    logic [DATA_W-1:0] lat_wdata;
    int                phase = 0;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + i;
        forever begin
            @(negedge clk);
            bus_gnt = bus_req;
            if (phase == 1) begin
                // R6: command lasted one cycle
                chk(!bus_cmd_valid, "R6 cmd one cycle", {31'b0, bus_cmd_valid}, 0);
                bus_ack   = 1'b1;
                bus_rdata = mem[lat_addr[7:0]];
                if (lat_we) mem[lat_addr[7:0]] = lat_wdata;
                phase = 2;
            end else if (phase == 2) begin
                bus_ack = 1'b0;
                phase   = 0;
            end
            if (bus_cmd_valid) begin
                ncmd++;
                lat_addr  = bus_addr;
                lat_we    = bus_cmd_we;
                lat_wdata = bus_wdata;
                chk(bus_req, "R6 req held in cmd", {31'b0, bus_req}, 1);
                chk(bus_addr == exp_addr, "R2 R4 cmd address", {16'b0, bus_addr}, {16'b0, exp_addr});
                chk(bus_cmd_we == exp_we, "R2 R4 cmd kind", {31'b0, bus_cmd_we}, {31'b0, exp_we});
                if (exp_we)
                    chk(bus_wdata == exp_wdata, "R4 cmd data", bus_wdata, exp_wdata);
                phase = 1;
            end
        end
    end

    // one processor operation; optional same-cycle foreign snoop write
    task automatic cpu_op(input logic we, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] wd, input bit with_snoop,
                          output logic [DATA_W-1:0] rd, output int lat,
                          output int nbus);
        int n0;
        @(negedge clk);
        n0 = ncmd;
        exp_we = we; exp_addr = a; exp_wdata = wd;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        if (with_snoop) begin
            ext_sv = 1'b1; ext_swe = 1'b1; ext_sa = a;
        end
        lat = 0;
        do begin
            @(negedge clk);
            ext_sv = 1'b0;
            lat++;
        end while (!cpu_ready && lat < 50);
        rd = cpu_rdata;
        cpu_req = 1'b0;
        chk(bus_req == 1'b0, "R6 req low at ready", {31'b0, bus_req}, 0);
        nbus = ncmd - n0;
    endtask

    task automatic snoop(input logic we, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        ext_sv = 1'b1; ext_swe = we; ext_sa = a;
        @(negedge clk);
        ext_sv = 1'b0;
    endtask

    // {we, addr, wdata, expected rdata, expects a bus command}
    localparam logic [81:0] VEC [NVEC] = '{
        {1'b0, 16'h0010, 32'h0,         32'hA000_0010, 1'b1},
        {1'b0, 16'h0010, 32'h0,         32'hA000_0010, 1'b0},
        {1'b1, 16'h0023, 32'h1111_1111, 32'h0,         1'b1},
        {1'b0, 16'h0023, 32'h0,         32'h1111_1111, 1'b1},
        {1'b1, 16'h0023, 32'h2222_2222, 32'h0,         1'b1},
        {1'b0, 16'h0023, 32'h0,         32'h2222_2222, 1'b0},
        {1'b0, 16'h0018, 32'h0,         32'hA000_0018, 1'b1},
        {1'b0, 16'h0010, 32'h0,         32'hA000_0010, 1'b1},
        {1'b0, 16'h0010, 32'h0,         32'hA000_0010, 1'b0}
    };

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] rd;
        int lat, nb;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!cpu_ready && !bus_req && !bus_cmd_valid, "R1 outputs in reset",
            {29'b0, cpu_ready, bus_req, bus_cmd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_ready && !bus_req, "R1 outputs after reset",
            {30'b0, cpu_ready, bus_req}, 0);

        // vector walk: R2 R3 R4 R9 R11
        for (int v = 0; v < NVEC; v++) begin
            cpu_op(VEC[v][81], VEC[v][80:65], VEC[v][64:33], 1'b0, rd, lat, nb);
            chk(nb == int'(VEC[v][0]), $sformatf("R2 R3 R4 R9 R11 vec %0d bus count", v),
                nb, {31'b0, VEC[v][0]});
            if (!VEC[v][81])
                chk(rd == VEC[v][32:1], $sformatf("R2 R3 R4 R11 vec %0d data", v),
                    rd, VEC[v][32:1]);
            if (!VEC[v][81] && !VEC[v][0])
                chk(lat == 1, $sformatf("R3 vec %0d hit latency", v), lat, 1);
        end

        // R5: foreign write drops the line
        mem[8'h10] = 32'h3333_3333;
        snoop(1'b1, 16'h0010);
        cpu_op(1'b0, 16'h0010, '0, 1'b0, rd, lat, nb);
        chk(nb == 1, "R5 read after foreign write misses", nb, 1);
        chk(rd == 32'h3333_3333, "R5 refetched data", rd, 32'h3333_3333);

        // R7: snooped read and tag-mismatch write leave line valid
        snoop(1'b0, 16'h0023);
        snoop(1'b1, 16'h002B);
        cpu_op(1'b0, 16'h0023, '0, 1'b0, rd, lat, nb);
        chk(nb == 0, "R7 line kept", nb, 0);
        chk(rd == 32'h2222_2222, "R7 data kept", rd, 32'h2222_2222);

        // R10: same-cycle foreign write and local read
        mem[8'h23] = 32'h4444_4444;
        cpu_op(1'b0, 16'h0023, '0, 1'b1, rd, lat, nb);
        chk(nb == 1, "R10 invalidation first", nb, 1);
        chk(rd == 32'h4444_4444, "R10 fresh data", rd, 32'h4444_4444);

        // R8: single pulse, controller idle afterwards
        cpu_op(1'b0, 16'h0023, '0, 1'b0, rd, lat, nb);
        chk(nb == 0 && lat == 1, "R8 hit before pulse check", nb, 0);
        @(negedge clk);
        chk(!cpu_ready, "R8 ready single cycle", {31'b0, cpu_ready}, 0);
        chk(!bus_req, "R8 bus idle after ready", {31'b0, bus_req}, 0);
        repeat (3) @(negedge clk);
        chk(ncmd == ncmd && !bus_cmd_valid, "R8 no stray command", {31'b0, bus_cmd_valid}, 0);

        // R1: mid-run reset empties the array
        rst_n = 1'b0;
        @(negedge clk);
        chk(!cpu_ready && !bus_req, "R1 outputs in second reset",
            {30'b0, cpu_ready, bus_req}, 0);
        rst_n = 1'b1;
        cpu_op(1'b0, 16'h0023, '0, 1'b0, rd, lat, nb);
        chk(nb == 1, "R1 read after reset misses", nb, 1);
        chk(rd == 32'h4444_4444, "R1 data after reset", rd, 32'h4444_4444);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule